// File: doc/BRIEF.md
# Interrupt Input Conditioner

This block sits in front of a pair of eight-bit interrupt request registers. Sixteen interrupt lines report events to it one at a time: a source raises the line, drops it, or pulses it. A line may be shared by several sources, so each line keeps a small saturating count of how many sources currently hold it. The count together with the line's trigger mode gives the outcome. The block then issues a one-cycle set or clear strobe for the matching request bit, or reports that the event changed nothing.

The trigger mode of each line is kept in one byte per controller. Line n belongs to controller n/8, bit n mod 8. Software reads and writes that byte whole over a byte port. A separate single-line request port can also pick level or edge mode for one line. Some lines are tied to edge mode: byte writes clear their bits, and single-line requests for level mode on them are refused. Events aimed at a controller that has not yet finished its initialisation are dropped.

Top module: `irq_input_conditioner`

## Requirements
- R1: An assert event (`ev_kind` 2'b00) raises the line count by one, saturating at 15. It gives a set strobe when the count was zero or the line is level mode, and an ignored strobe otherwise.
- R2: On a level-mode line, a deassert event (`ev_kind` 2'b01) whose count goes from 1 to 0 gives a clear strobe. One whose count stays above zero gives a set strobe.
- R3: On an edge-mode line, a deassert event from count 1 gives no strobe at all, so the request stays latched. A deassert from a count above 1 gives an ignored strobe.
- R4: A deassert at count zero leaves the count at zero, gives an ignored strobe and sets the line's bit in `cnt_err`. Only reset clears `cnt_err` bits.
- R5: A pulse event (`ev_kind` 2'b10) leaves the count unchanged. On an edge line it gives a set strobe at count zero and an ignored strobe otherwise. On a level line it gives a clear strobe at count zero and a set strobe otherwise.
- R6: A byte write stores `cfg_wdata & 8'hF8` for controller 0 (`cfg_sel`=0) and `cfg_wdata & 8'hDE` for controller 1 (`cfg_sel`=1). This forces lines 0, 1, 2, 8 and 13 to edge mode. `cfg_rdata` returns the stored byte of the selected controller, where 1 means level mode.
- R7: A single-line mode request is refused, with `trig_reject` high one cycle later and no change to the mode, when the line number is 16 or more, or when level mode is asked for on line 0, 1, 2, 8 or 13. Any other request writes `trig_level` into the line's mode bit.
- R8: An event with a line number of 16 or more, or with the reserved kind 2'b11, raises `ev_reject`. It produces no strobe and changes no count.
- R9: An event on a line whose controller's `ctrl_ready` bit is low produces no strobe of any kind and changes no count.
- R10: Strobes appear on the cycle after the event, on bit n of `req_set` or `req_clr` for line n. An event is judged with the mode stored before its cycle. A byte write and a single-line request to the same controller in one cycle leave the byte write's value.
- R11: After reset all counts, modes, strobes and error bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_ready | input | 2 | Per-controller initialisation complete |
| ev_valid | input | 1 | Event present this cycle |
| ev_pin | input | 5 | Line number of the event |
| ev_kind | input | 2 | 00 assert, 01 deassert, 10 pulse, 11 reserved |
| cfg_wr | input | 1 | Write the mode byte |
| cfg_sel | input | 1 | Controller selected for byte read/write |
| cfg_wdata | input | 8 | Mode byte write data |
| cfg_rdata | output | 8 | Stored mode byte of selected controller |
| trig_valid | input | 1 | Single-line mode request present |
| trig_pin | input | 5 | Line number of the mode request |
| trig_level | input | 1 | 1 asks for level mode, 0 for edge |
| trig_reject | output | 1 | Previous mode request refused |
| req_set | output | 16 | One-cycle request set strobes |
| req_clr | output | 16 | One-cycle request clear strobes |
| ev_ignored | output | 1 | Previous event left the request unchanged |
| ev_reject | output | 1 | Previous event was malformed |
| cnt_err | output | 16 | Sticky per-line underflow flags |

## Verification
The collision of interest is an event on a line and a mode change of that same line in the same clock cycle. The bench provokes it by pulsing an idle edge line while a single-line request turns that line to level mode. It judges the result by the strobe kind: a set proves the old edge mode was used, and a second pulse that now yields a clear proves the new mode took hold. A byte write and a single-line request landing on one controller in one cycle are also driven together, and the read-back byte decides which one won.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        EV_ASSERT   = 2'b00,
        EV_DEASSERT = 2'b01,
        EV_PULSE    = 2'b10,
        EV_RSVD     = 2'b11
    } ev_kind_e;

    typedef enum logic [1:0] {
        RES_SET,
        RES_CLR,
        RES_HOLD,
        RES_IGN
    } result_e;

endpackage

// File: rtl/irqc_line_count.sv
module irqc_line_count
    import irqc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  ev_kind_e kind,
    input  logic     level,
    output logic     set_o,
    output logic     clr_o,
    output logic     ign_o,
    output logic     err_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             err_q;
    logic             under;
    result_e          res;
    logic             is_zero;
    logic             is_one;
    logic             is_full;

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == CNT_W'(1));
    assign is_full = &cnt_q;

    always_comb begin
        cnt_nxt = cnt_q;
        res     = RES_IGN;
        under   = 1'b0;
        unique case (kind)
            EV_ASSERT: begin
                cnt_nxt = is_full ? cnt_q : cnt_q + CNT_W'(1);
                res     = (is_zero || level) ? RES_SET : RES_IGN;
            end
            EV_DEASSERT: begin
                if (is_zero) begin
                    under = 1'b1;
                    res   = RES_IGN;
                end else begin
                    cnt_nxt = cnt_q - CNT_W'(1);
                    if (level) res = is_one ? RES_CLR : RES_SET;
                    else       res = is_one ? RES_HOLD : RES_IGN;
                end
            end
            EV_PULSE: begin
                if (level) res = is_zero ? RES_CLR : RES_SET;
                else       res = is_zero ? RES_SET : RES_IGN;
            end
            EV_RSVD: res = RES_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= cnt_nxt;
            if (under) err_q <= 1'b1;
        end
    end

    assign set_o = hit && (res == RES_SET);
    assign clr_o = hit && (res == RES_CLR);
    assign ign_o = hit && (res == RES_IGN);
    assign err_o = err_q;

endmodule

// File: rtl/irqc_mode_regs.sv
module irqc_mode_regs #(
    parameter int                NPINS     = 16,
    parameter int                CTRL_W    = 8,
    parameter logic [NPINS-1:0]  EDGE_ONLY = 16'h2107,
    localparam int               NCTRL     = NPINS / CTRL_W,
    localparam int               SEL_W     = (NCTRL > 1) ? $clog2(NCTRL) : 1,
    localparam int               PIN_W     = $clog2(NPINS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              trig_valid,
    input  logic [PIN_W-1:0]  trig_pin,
    input  logic              trig_level,
    output logic              trig_reject,
    output logic [NPINS-1:0]  mode
);

    logic [NPINS-1:0] mode_q;
    logic             trig_rej_q;
    logic             trig_in_range;
    logic             trig_ok;

    assign trig_in_range = (trig_pin < PIN_W'(NPINS));
    assign trig_ok = trig_valid && trig_in_range &&
                     !(trig_level && EDGE_ONLY[trig_pin[PIN_W-2:0]]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            trig_rej_q <= 1'b0;
        end else begin
            trig_rej_q <= trig_valid && !trig_ok;
            for (int p = 0; p < NPINS; p++) begin
                if (cfg_wr && (cfg_sel == SEL_W'(p / CTRL_W)))
                    mode_q[p] <= cfg_wdata[p % CTRL_W] && !EDGE_ONLY[p];
                else if (trig_ok && (trig_pin == PIN_W'(p)))
                    mode_q[p] <= trig_level;
            end
        end
    end

    assign cfg_rdata   = mode_q[cfg_sel*CTRL_W +: CTRL_W];
    assign trig_reject = trig_rej_q;
    assign mode        = mode_q;

endmodule

// File: rtl/irq_input_conditioner.sv
module irq_input_conditioner
    import irqc_pkg::*;
#(
    parameter int                NPINS     = 16,
    parameter int                CTRL_W    = 8,
    parameter int                CNT_W     = 4,
    parameter logic [NPINS-1:0]  EDGE_ONLY = 16'h2107,
    localparam int               NCTRL     = NPINS / CTRL_W,
    localparam int               SEL_W     = (NCTRL > 1) ? $clog2(NCTRL) : 1,
    localparam int               PIN_W     = $clog2(NPINS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCTRL-1:0]  ctrl_ready,
    input  logic              ev_valid,
    input  logic [PIN_W-1:0]  ev_pin,
    input  logic [1:0]        ev_kind,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              trig_valid,
    input  logic [PIN_W-1:0]  trig_pin,
    input  logic              trig_level,
    output logic              trig_reject,
    output logic [NPINS-1:0]  req_set,
    output logic [NPINS-1:0]  req_clr,
    output logic              ev_ignored,
    output logic              ev_reject,
    output logic [NPINS-1:0]  cnt_err
);

    ev_kind_e         kind;
    logic             kind_ok;
    logic             pin_ok;
    logic [NPINS-1:0] mode_w;
    logic [NPINS-1:0] hit_v;
    logic [NPINS-1:0] set_v;
    logic [NPINS-1:0] clr_v;
    logic [NPINS-1:0] ign_v;
    logic [NPINS-1:0] set_q;
    logic [NPINS-1:0] clr_q;
    logic             ign_q;
    logic             rej_q;

    assign kind    = ev_kind_e'(ev_kind);
    assign kind_ok = (kind != EV_RSVD);
    assign pin_ok  = (ev_pin < PIN_W'(NPINS));

    irqc_mode_regs #(
        .NPINS     (NPINS),
        .CTRL_W    (CTRL_W),
        .EDGE_ONLY (EDGE_ONLY)
    ) u_modes (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .trig_valid  (trig_valid),
        .trig_pin    (trig_pin),
        .trig_level  (trig_level),
        .trig_reject (trig_reject),
        .mode        (mode_w)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_line
        assign hit_v[p] = ev_valid && kind_ok && (ev_pin == PIN_W'(p)) &&
                          ctrl_ready[p / CTRL_W];

        irqc_line_count #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_v[p]),
            .kind  (kind),
            .level (mode_w[p]),
            .set_o (set_v[p]),
            .clr_o (clr_v[p]),
            .ign_o (ign_v[p]),
            .err_o (cnt_err[p])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            clr_q <= '0;
            ign_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            set_q <= set_v;
            clr_q <= clr_v;
            ign_q <= |ign_v;
            rej_q <= ev_valid && (!pin_ok || !kind_ok);
        end
    end

    assign req_set    = set_q;
    assign req_clr    = clr_q;
    assign ev_ignored = ign_q;
    assign ev_reject  = rej_q;

endmodule

// File: rtl/irq_input_conditioner_chk.sv
module irq_input_conditioner_chk #(
    parameter int                NPINS     = 16,
    parameter int                CTRL_W    = 8,
    parameter logic [NPINS-1:0]  EDGE_ONLY = 16'h2107,
    localparam int               NCTRL     = NPINS / CTRL_W,
    localparam int               PIN_W     = $clog2(NPINS) + 1,
    localparam int               LOG_W     = $clog2(CTRL_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCTRL-1:0] ctrl_ready,
    input logic             ev_valid,
    input logic [PIN_W-1:0] ev_pin,
    input logic             trig_valid,
    input logic [PIN_W-1:0] trig_pin,
    input logic             trig_level,
    input logic             trig_reject,
    input logic [NPINS-1:0] req_set,
    input logic [NPINS-1:0] req_clr,
    input logic             ev_ignored,
    input logic             ev_reject,
    input logic [NPINS-1:0] cnt_err,
    input logic [NPINS-1:0] mode
);

    AST_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode & EDGE_ONLY) == '0); // R6

    AST_ONE_LINE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_set | req_clr)); // R10

    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_pin >= PIN_W'(NPINS)) |=>
        (ev_reject && req_set == '0 && req_clr == '0)); // R8

    AST_NOT_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_pin < PIN_W'(NPINS) &&
         !ctrl_ready[ev_pin[PIN_W-2:LOG_W]]) |=>
        (req_set == '0 && req_clr == '0 && !ev_ignored)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_err & $past(cnt_err)) == $past(cnt_err))); // R4

    AST_FIXED_LEVEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_level && trig_pin < PIN_W'(NPINS) &&
         EDGE_ONLY[trig_pin[PIN_W-2:0]]) |=> trig_reject); // R7

endmodule

bind irq_input_conditioner irq_input_conditioner_chk #(
    .NPINS     (NPINS),
    .CTRL_W    (CTRL_W),
    .EDGE_ONLY (EDGE_ONLY)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_ready  (ctrl_ready),
    .ev_valid    (ev_valid),
    .ev_pin      (ev_pin),
    .trig_valid  (trig_valid),
    .trig_pin    (trig_pin),
    .trig_level  (trig_level),
    .trig_reject (trig_reject),
    .req_set     (req_set),
    .req_clr     (req_clr),
    .ev_ignored  (ev_ignored),
    .ev_reject   (ev_reject),
    .cnt_err     (cnt_err),
    .mode        (mode_w)
);

// File: tb/irq_input_conditioner_bench.sv
module irq_input_conditioner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctrl_ready = 2'b11;
    logic        ev_valid = 1'b0;
    logic [4:0]  ev_pin = '0;
    logic [1:0]  ev_kind = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        trig_valid = 1'b0;
    logic [4:0]  trig_pin = '0;
    logic        trig_level = 1'b0;
    logic        trig_reject;
    logic [15:0] req_set;
    logic [15:0] req_clr;
    logic        ev_ignored;
    logic        ev_reject;
    logic [15:0] cnt_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_input_conditioner u_irq_input_conditioner (
        .clk, .rst_n, .ctrl_ready, .ev_valid, .ev_pin, .ev_kind,
        .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata,
        .trig_valid, .trig_pin, .trig_level, .trig_reject,
        .req_set, .req_clr, .ev_ignored, .ev_reject, .cnt_err
    );

    // fields: kind[9:8] pin[7:3] set[2] clr[1] ign[0]
    localparam int NV = 17;
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 5'd3,  3'b100},  // R1 edge first assert
        {2'd0, 5'd3,  3'b001},  // R1 edge second assert
        {2'd1, 5'd3,  3'b001},  // R3 2->1 edge
        {2'd1, 5'd3,  3'b000},  // R3 1->0 edge latched
        {2'd2, 5'd3,  3'b100},  // R5 edge pulse at zero
        {2'd1, 5'd3,  3'b001},  // R4 underflow
        {2'd0, 5'd5,  3'b100},  // R1 level assert
        {2'd0, 5'd5,  3'b100},  // R1 level second assert
        {2'd1, 5'd5,  3'b100},  // R2 2->1 level
        {2'd2, 5'd5,  3'b100},  // R5 level pulse nonzero
        {2'd1, 5'd5,  3'b010},  // R2 1->0 level
        {2'd2, 5'd5,  3'b010},  // R5 level pulse at zero
        {2'd0, 5'd9,  3'b100},  // R10 slave line bit 9
        {2'd1, 5'd9,  3'b010},  // R2 slave level clear
        {2'd2, 5'd8,  3'b100},  // R6 forced edge line 8
        {2'd0, 5'd13, 3'b100},  // R6 forced edge line 13
        {2'd0, 5'd13, 3'b001}   // R6 line 13 stays edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_ev(input logic [1:0] k, input logic [4:0] p);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_pin = p;
        @(posedge clk);
        #1 ev_valid = 1'b0;
        #1;
    endtask

    task automatic expect_ev(input string req, input logic [4:0] p,
                             input logic s, input logic c, input logic ig);
        logic [15:0] m;
        m = (p < 16) ? (16'h1 << p) : 16'h0;
        check({req, " set"}, 32'(req_set), s ? 32'(m) : 32'h0);
        check({req, " clr"}, 32'(req_clr), c ? 32'(m) : 32'h0);
        check({req, " ign"}, 32'(ev_ignored), 32'(ig));
    endtask

    task automatic send_trig(input logic [4:0] p, input logic lvl);
        @(negedge clk);
        trig_valid = 1'b1; trig_pin = p; trig_level = lvl;
        @(posedge clk);
        #1 trig_valid = 1'b0;
        #1;
    endtask

    task automatic write_byte(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
        #1;
    endtask

    task automatic read_byte(input string req, input logic sel, input logic [7:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1 check(req, 32'(cfg_rdata), 32'(exp));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        #1;
        check("R11 set", 32'(req_set), 0);
        check("R11 clr", 32'(req_clr), 0);
        check("R11 err", 32'(cnt_err), 0);
        check("R11 flags", {29'd0, ev_ignored, ev_reject, trig_reject}, 0);
        read_byte("R11 mode0", 1'b0, 8'h00);
        read_byte("R11 mode1", 1'b1, 8'h00);

        // configuration
        send_trig(5'd5, 1'b1);
        check("R7 accept line 5", 32'(trig_reject), 0);
        write_byte(1'b1, 8'hFF);
        read_byte("R6 slave mask", 1'b1, 8'hDE);
        read_byte("R7 line 5 level", 1'b0, 8'h20);

        // table walk
        for (int i = 0; i < NV; i++) begin
            send_ev(VEC[i][9:8], VEC[i][7:3]);
            expect_ev($sformatf("R1-vec%0d", i), VEC[i][7:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        check("R4 err after underflow", 32'(cnt_err), 32'h0008);

        // R7 rejections
        send_trig(5'd0, 1'b1);
        check("R7 line 0 level", 32'(trig_reject), 1);
        send_trig(5'd13, 1'b1);
        check("R7 line 13 level", 32'(trig_reject), 1);
        send_trig(5'd20, 1'b0);
        check("R7 range", 32'(trig_reject), 1);
        send_trig(5'd0, 1'b0);
        check("R7 line 0 edge ok", 32'(trig_reject), 0);
        read_byte("R7 mode unchanged", 1'b0, 8'h20);

        // R8 malformed events
        send_ev(2'd0, 5'd17);
        check("R8 range reject", 32'(ev_reject), 1);
        expect_ev("R8 range quiet", 5'd17, 0, 0, 0);
        send_ev(2'd3, 5'd7);
        check("R8 rsvd reject", 32'(ev_reject), 1);
        expect_ev("R8 rsvd quiet", 5'd7, 0, 0, 0);
        send_ev(2'd0, 5'd7);
        expect_ev("R8 count untouched", 5'd7, 1, 0, 0);

        // R9 controller not ready
        ctrl_ready = 2'b01;
        send_ev(2'd0, 5'd10);
        expect_ev("R9 dropped", 5'd10, 0, 0, 0);
        ctrl_ready = 2'b11;
        send_ev(2'd1, 5'd10);
        expect_ev("R9 count still zero", 5'd10, 0, 0, 1);
        check("R9 underflow flag", 32'(cnt_err[10]), 1);

        // R1 saturation on edge line 4
        send_ev(2'd0, 5'd4);
        expect_ev("R1 sat first", 5'd4, 1, 0, 0);
        for (int i = 0; i < 15; i++) send_ev(2'd0, 5'd4);
        expect_ev("R1 sat last", 5'd4, 0, 0, 1);
        for (int i = 0; i < 14; i++) send_ev(2'd1, 5'd4);
        expect_ev("R3 sat down", 5'd4, 0, 0, 1);
        send_ev(2'd1, 5'd4);
        expect_ev("R3 sat to zero", 5'd4, 0, 0, 0);
        check("R4 no err yet", 32'(cnt_err[4]), 0);
        send_ev(2'd1, 5'd4);
        expect_ev("R4 sat underflow", 5'd4, 0, 0, 1);
        check("R4 err set", 32'(cnt_err[4]), 1);

        // R10 event and mode change in one cycle
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 2'd2; ev_pin = 5'd6;
        trig_valid = 1'b1; trig_pin = 5'd6; trig_level = 1'b1;
        @(posedge clk);
        #1 ev_valid = 1'b0; trig_valid = 1'b0;
        #1 expect_ev("R10 old mode used", 5'd6, 1, 0, 0);
        send_ev(2'd2, 5'd6);
        expect_ev("R10 new mode used", 5'd6, 0, 1, 0);

        // R6 master byte mask
        write_byte(1'b0, 8'hFF);
        read_byte("R6 master mask", 1'b0, 8'hF8);

        // R10 byte write beats line request
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h00;
        trig_valid = 1'b1; trig_pin = 5'd5; trig_level = 1'b1;
        @(posedge clk);
        #1 cfg_wr = 1'b0; trig_valid = 1'b0;
        read_byte("R10 write wins", 1'b0, 8'h00);

        check("R4 sticky errs", 32'(cnt_err), 32'h0418);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule